// File: doc/BRIEF.md
# Interprocessor interrupt command unit

This unit turns a 64-bit command, written by software as two 32-bit words, into one interrupt message sent to other processors. A write to the upper word only stores the 4-bit destination ID. A write to the lower word launches the message. It carries the delivery mode, vector and level from that write, and a target bit mask resolved from the destination, the destination mode and the shorthand field.

After launch, the message and a delivery-status output stay asserted until a target accepts it through a single-cycle `accept_i` handshake. Software polls the status to learn when the unit is free. Targets are numbered 0 to `N_TGT-1`, and target i has physical ID i. The sending processor's ID arrives on `self_id_i`.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset, `msg_valid_o`, `status_o` and `err_o` are 0.
- R2: A write to the upper word (`wr_hi_i`) stores `wdata_i[27:24]` as the destination ID, which is bits 59:56 of the full command. It launches no message.
- R3: A write to the lower word while no message is pending launches on the next clock edge. From that edge, `msg_valid_o` and `status_o` read 1, `msg_mode_o` = `wdata_i[10:8]`, `msg_level_o` = `wdata_i[14]` and `msg_vector_o` = `wdata_i[7:0]`. The vector is subject to R7.
- R4: With shorthand `wdata_i[19:18]`=00 and physical destination mode (`wdata_i[11]`=0), the mask has exactly the bit of the stored destination ID set. Logical mode (`wdata_i[11]`=1), or a destination ID of `N_TGT` or more, selects no target, and then no message is launched.
- R5: Shorthand 01 selects only `self_id_i`, 10 selects all targets and 11 selects all targets except `self_id_i`. The stored destination and the destination mode are ignored.
- R6: Mode 101 (INIT) with level 0 and trigger bit `wdata_i[15]`=1 selects all targets, whatever the destination and shorthand.
- R7: For mode 100 (NMI) and 101 (INIT), `msg_vector_o` is 0. For every other mode, including 110 (startup), the vector passes unchanged.
- R8: While `msg_valid_o` is 1 and `accept_i` is 0, every message output holds. One edge after `accept_i` is seen with `msg_valid_o`=1, `msg_valid_o` and `status_o` return to 0. The message is never sent again on its own.
- R9: A lower-word write while a message is pending is ignored, and the pending message is unchanged.
- R10: A lower-word write with reserved mode 011 launches nothing and sets `err_o` to 1. The next accepted lower-word write with any other mode clears `err_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_lo_i | input | 1 | Write strobe for the lower command word (launches) |
| wr_hi_i | input | 1 | Write strobe for the upper command word |
| wdata_i | input | 32 | Write data |
| self_id_i | input | 4 | ID of the sending processor |
| accept_i | input | 1 | Target accepts the pending message |
| msg_valid_o | output | 1 | Message being offered |
| msg_mask_o | output | N_TGT | Target bit mask |
| msg_mode_o | output | 3 | Delivery mode |
| msg_vector_o | output | 8 | Vector or startup page |
| msg_level_o | output | 1 | Level bit |
| status_o | output | 1 | Delivery pending |
| err_o | output | 1 | Reserved mode was written |

## Verification
The bench covers the following corner cases, each with the fault it would expose:
- An out-of-range destination and logical mode: a design that let these through would launch a message with an empty mask, or with a wrapped target.
- Shorthands written with a conflicting destination stored: a design that did not ignore the stored destination would mix it into the mask.
- The INIT de-assert case with an out-of-range destination: a design that missed this case would drop the message.
- Lower-word writes during a pending message: a design that did not ignore them would corrupt or retarget the message.
- The cycles after accept: a design that retried the message would raise valid again.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  typedef enum logic [2:0] {
    DM_FIXED  = 3'b000,
    DM_LOWPRI = 3'b001,
    DM_SMI    = 3'b010,
    DM_RSVD   = 3'b011,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_START  = 3'b110,
    DM_OTHER  = 3'b111
  } dmode_e;

  typedef enum logic [1:0] {
    SH_NONE    = 2'b00,
    SH_SELF    = 2'b01,
    SH_ALL     = 2'b10,
    SH_ALLBUT  = 2'b11
  } shorthand_e;

  localparam int unsigned ID_W      = 4;
  localparam int unsigned VEC_LSB   = 0;
  localparam int unsigned MODE_LSB  = 8;
  localparam int unsigned DMODE_BIT = 11;
  localparam int unsigned LVL_BIT   = 14;
  localparam int unsigned TRG_BIT   = 15;
  localparam int unsigned SH_LSB    = 18;
  localparam int unsigned DEST_LSB  = 24;
endpackage

// File: rtl/ipi_dest_decode.sv
module ipi_dest_decode
  import ipi_pkg::*;
#(
  parameter int unsigned N_TGT = 8
) (
  input  shorthand_e       sh_i,
  input  logic             logical_i,
  input  logic [ID_W-1:0]  dest_i,
  input  logic [ID_W-1:0]  self_i,
  input  dmode_e           mode_i,
  input  logic             level_i,
  input  logic             trig_i,
  output logic [N_TGT-1:0] mask_o
);
  logic init_deassert;
  assign init_deassert = (mode_i == DM_INIT) && !level_i && trig_i;

  for (genvar i = 0; i < N_TGT; i++) begin : g_tgt
    logic is_self, is_dest;
    assign is_self = (32'(self_i) == i);
    assign is_dest = !logical_i && (32'(dest_i) == i);
    always_comb begin
      if (init_deassert) mask_o[i] = 1'b1;
      else begin
        unique case (sh_i)
          SH_NONE:   mask_o[i] = is_dest;
          SH_SELF:   mask_o[i] = is_self;
          SH_ALL:    mask_o[i] = 1'b1;
          SH_ALLBUT: mask_o[i] = !is_self;
          default:   mask_o[i] = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ipi_msg_launch.sv
module ipi_msg_launch
  import ipi_pkg::*;
#(
  parameter int unsigned N_TGT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             accept_i,
  input  dmode_e           mode_i,
  input  logic [7:0]       vector_i,
  input  logic             level_i,
  input  logic [N_TGT-1:0] mask_i,
  output logic             valid_o,
  output logic [N_TGT-1:0] mask_o,
  output logic [2:0]       mode_o,
  output logic [7:0]       vector_o,
  output logic             level_o
);
  logic no_vec;
  assign no_vec = (mode_i == DM_NMI) || (mode_i == DM_INIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      mask_o   <= '0;
      mode_o   <= '0;
      vector_o <= '0;
      level_o  <= 1'b0;
    end else if (!valid_o) begin
      if (launch_i) begin
        valid_o  <= 1'b1;
        mask_o   <= mask_i;
        mode_o   <= mode_i;
        vector_o <= no_vec ? 8'h00 : vector_i;
        level_o  <= level_i;
      end
    end else if (accept_i) begin
      valid_o <= 1'b0; // no automatic retry
    end
  end
endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
  import ipi_pkg::*;
#(
  parameter int unsigned N_TGT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [31:0]      wdata_i,
  input  logic [3:0]       self_id_i,
  input  logic             accept_i,
  output logic             msg_valid_o,
  output logic [N_TGT-1:0] msg_mask_o,
  output logic [2:0]       msg_mode_o,
  output logic [7:0]       msg_vector_o,
  output logic             msg_level_o,
  output logic             status_o,
  output logic             err_o
);
  logic [ID_W-1:0]  dest_q;
  logic [N_TGT-1:0] mask_d;
  dmode_e           mode_d;
  logic             wr_take, launch;

  assign mode_d  = dmode_e'(wdata_i[MODE_LSB +: 3]);
  assign wr_take = wr_lo_i && !msg_valid_o;
  assign launch  = wr_take && (mode_d != DM_RSVD) && (|mask_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dest_q <= '0;
      err_o  <= 1'b0;
    end else begin
      if (wr_hi_i) dest_q <= wdata_i[DEST_LSB +: ID_W];
      if (wr_take) err_o <= (mode_d == DM_RSVD);
    end
  end

  ipi_dest_decode #(.N_TGT(N_TGT)) u_dec (
    .sh_i      (shorthand_e'(wdata_i[SH_LSB +: 2])),
    .logical_i (wdata_i[DMODE_BIT]),
    .dest_i    (dest_q),
    .self_i    (self_id_i),
    .mode_i    (mode_d),
    .level_i   (wdata_i[LVL_BIT]),
    .trig_i    (wdata_i[TRG_BIT]),
    .mask_o    (mask_d)
  );

  ipi_msg_launch #(.N_TGT(N_TGT)) u_launch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .accept_i (accept_i),
    .mode_i   (mode_d),
    .vector_i (wdata_i[VEC_LSB +: 8]),
    .level_i  (wdata_i[LVL_BIT]),
    .mask_i   (mask_d),
    .valid_o  (msg_valid_o),
    .mask_o   (msg_mask_o),
    .mode_o   (msg_mode_o),
    .vector_o (msg_vector_o),
    .level_o  (msg_level_o)
  );

  assign status_o = msg_valid_o;
endmodule

// File: rtl/ipi_cmd_unit_chk.sv
module ipi_cmd_unit_chk #(
  parameter int unsigned N_TGT = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_lo_i,
  input logic             accept_i,
  input logic             msg_valid_o,
  input logic [N_TGT-1:0] msg_mask_o,
  input logic [2:0]       msg_mode_o,
  input logic [7:0]       msg_vector_o,
  input logic             msg_level_o
);
  AST_LAUNCH_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_valid_o) |-> $past(wr_lo_i)); // R3
  AST_NONEMPTY_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> (msg_mask_o != '0)); // R4
  AST_NO_VEC_NMI_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && (msg_mode_o == 3'b100 || msg_mode_o == 3'b101)) |-> (msg_vector_o == 8'h00)); // R7
  AST_HOLD_UNTIL_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !accept_i) |=> (msg_valid_o && $stable(msg_mask_o) && $stable(msg_mode_o)
                                   && $stable(msg_vector_o) && $stable(msg_level_o))); // R8
  AST_ACCEPT_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && accept_i) |=> !msg_valid_o); // R8
  AST_NO_RESERVED_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> (msg_mode_o != 3'b011)); // R10
endmodule

bind ipi_cmd_unit ipi_cmd_unit_chk #(.N_TGT(N_TGT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_lo_i      (wr_lo_i),
  .accept_i     (accept_i),
  .msg_valid_o  (msg_valid_o),
  .msg_mask_o   (msg_mask_o),
  .msg_mode_o   (msg_mode_o),
  .msg_vector_o (msg_vector_o),
  .msg_level_o  (msg_level_o)
);

// File: tb/ipi_cmd_unit_tb.sv
module ipi_cmd_unit_tb_top;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_lo = 1'b0, wr_hi = 1'b0, accept = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0] self_id = 4'd3;
  logic valid, lvl, status, err;
  logic [N-1:0] mask;
  logic [2:0] mode;
  logic [7:0] vec;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ipi_cmd_unit #(.N_TGT(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wdata_i(wdata),
    .self_id_i(self_id), .accept_i(accept), .msg_valid_o(valid), .msg_mask_o(mask),
    .msg_mode_o(mode), .msg_vector_o(vec), .msg_level_o(lvl), .status_o(status), .err_o(err)
  );

  function automatic logic [31:0] lo(input logic [7:0] v, input logic [2:0] m, input logic dm,
                                     input logic l, input logic t, input logic [1:0] sh);
    return {12'h0, sh, 2'b00, t, l, 2'b00, dm, m, v};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_hi(input logic [3:0] d);
    @(negedge clk); wr_hi = 1'b1; wdata = {4'h0, d, 24'h0};
    @(negedge clk); wr_hi = 1'b0;
  endtask

  task automatic write_lo(input logic [31:0] w);
    @(negedge clk); wr_lo = 1'b1; wdata = w;
    @(negedge clk); wr_lo = 1'b0;
  endtask

  task automatic do_accept();
    @(negedge clk); accept = 1'b1;
    @(negedge clk); accept = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 valid", 32'(valid), 0);
    chk("R1 status", 32'(status), 0);
    chk("R1 err", 32'(err), 0);
  endtask

  task automatic t_fixed_phys();
    write_hi(4'd5);
    chk("R2 no launch on high write", 32'(valid), 0);
    write_lo(lo(8'h40, 3'b000, 1'b0, 1'b1, 1'b0, 2'b00));
    chk("R3 valid", 32'(valid), 1);
    chk("R3 status", 32'(status), 1);
    chk("R3 mode", 32'(mode), 0);
    chk("R3 vector", 32'(vec), 32'h40);
    chk("R3 level", 32'(lvl), 1);
    chk("R4 mask dest 5", 32'(mask), 32'h20);
    repeat (3) @(negedge clk);
    chk("R8 held valid", 32'(valid), 1);
    chk("R8 held mask", 32'(mask), 32'h20);
    write_lo(lo(8'h11, 3'b001, 1'b0, 1'b0, 1'b0, 2'b10));
    chk("R9 mask unchanged", 32'(mask), 32'h20);
    chk("R9 vector unchanged", 32'(vec), 32'h40);
    do_accept();
    chk("R8 valid drops", 32'(valid), 0);
    chk("R8 status drops", 32'(status), 0);
  endtask

  task automatic t_no_target();
    write_hi(4'd12);
    write_lo(lo(8'h22, 3'b000, 1'b0, 1'b0, 1'b0, 2'b00));
    chk("R4 out of range dest", 32'(valid), 0);
    write_hi(4'd2);
    write_lo(lo(8'h22, 3'b000, 1'b1, 1'b0, 1'b0, 2'b00));
    chk("R4 logical mode", 32'(valid), 0);
  endtask

  task automatic t_shorthand();
    write_hi(4'd5);
    write_lo(lo(8'h31, 3'b000, 1'b0, 1'b0, 1'b0, 2'b01));
    chk("R5 self mask", 32'(mask), 32'h08);
    do_accept();
    write_lo(lo(8'h32, 3'b000, 1'b1, 1'b0, 1'b0, 2'b10));
    chk("R5 all mask", 32'(mask), 32'hFF);
    do_accept();
    write_lo(lo(8'h33, 3'b000, 1'b0, 1'b0, 1'b0, 2'b11));
    chk("R5 all-but-self mask", 32'(mask), 32'hF7);
    do_accept();
  endtask

  task automatic t_init();
    write_hi(4'd9);
    write_lo(lo(8'h55, 3'b101, 1'b0, 1'b0, 1'b1, 2'b00));
    chk("R6 deassert valid", 32'(valid), 1);
    chk("R6 deassert mask", 32'(mask), 32'hFF);
    chk("R7 init vector", 32'(vec), 0);
    do_accept();
    write_lo(lo(8'h55, 3'b101, 1'b0, 1'b1, 1'b0, 2'b00));
    chk("R6 assert follows dest", 32'(valid), 0);
  endtask

  task automatic t_nmi_startup();
    write_hi(4'd1);
    write_lo(lo(8'h77, 3'b100, 1'b0, 1'b1, 1'b0, 2'b00));
    chk("R7 nmi vector", 32'(vec), 0);
    chk("R7 nmi mode", 32'(mode), 4);
    do_accept();
    write_lo(lo(8'h9A, 3'b110, 1'b0, 1'b1, 1'b0, 2'b00));
    chk("R7 startup vector", 32'(vec), 32'h9A);
    chk("R7 startup mask", 32'(mask), 32'h02);
    do_accept();
    repeat (4) @(negedge clk);
    chk("R8 no resend", 32'(valid), 0);
  endtask

  task automatic t_reserved();
    write_hi(4'd0);
    write_lo(lo(8'h10, 3'b011, 1'b0, 1'b1, 1'b0, 2'b00));
    chk("R10 no launch", 32'(valid), 0);
    chk("R10 err set", 32'(err), 1);
    write_lo(lo(8'h10, 3'b000, 1'b0, 1'b1, 1'b0, 2'b00));
    chk("R10 err cleared", 32'(err), 0);
    chk("R10 launch after", 32'(valid), 1);
    do_accept();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_fixed_phys();
    t_no_target();
    t_shorthand();
    t_init();
    t_nmi_startup();
    t_reserved();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule